// File: doc/BRIEF.md
# Fractional Baud Tick Divider

This block turns the system clock into a one-cycle oversampling tick for a LIN-style serial transmitter and receiver. The programmed divisor has two parts. The integer part is an 8-bit value, and the fractional part is a 4-bit value counted in sixteenths. The average tick spacing therefore equals `integer + fraction/16` system clocks.

A 4-bit phase accumulator adds the fraction once per period. Whenever that sum carries out, the current period is one clock longer. Over sixteen periods the extra clocks add up to exactly the programmed fraction.

Software reaches the block through two byte-wide registers on a small write/read bus. Address 0 holds the integer part and address 1 holds the fraction.

The fraction is only staged when it is written. A write to the integer register is what applies the new integer and the staged fraction together. That write also restarts the period counter and the accumulator. An integer value of zero stops the tick entirely.

Top module: `baud_frac_div`

## Requirements
- R1: Over any 16 consecutive tick intervals after a commit, the total number of system clocks is exactly 16 × integer + fraction.
- R2: The fraction register is at address 1 and holds `wdata[3:0]`. Reading address 1 returns that staged value in bits 3:0, and bits 7:4 always read as zero.
- R3: After reset, both registers read 00h and no tick is produced.
- R4: Writing the fraction register alone leaves the tick timing of the active divisor unchanged.
- R5: Writing the integer register (address 0) commits that value together with the staged fraction. The first tick after the commit comes exactly `integer` clocks after the committing edge.
- R6: While the active integer part is zero, the tick stays low.
- R7: With an active integer part of 2 or more, every tick is high for exactly one clock cycle.
- R8: Each tick interval is `integer` clocks, or one clock more when adding the fraction to the 4-bit accumulator carries out. The accumulator keeps the low 4 bits of that sum and is cleared at each commit.
- R9: Reading address 0 returns the last value written to the integer register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising edge |
| addr | input | 1 | Register select: 0 integer part, 1 fraction |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data of the register selected by `addr` |
| tick | output | 1 | One-cycle oversampling tick |

## Verification
A wrong counter or accumulator value changes the tick position. The tick is compared every clock against an independent timing model, so such a fault appears at the next expected tick. That is at most 256 clocks after the fault.

A fraction that is lost or applied early changes the length of a period only when the accumulator carries. The 16-interval window sum makes that fault visible within sixteen periods.

A staging or commit fault shows up in two places: at once on the read-back port, and within the first period after the next integer-register write.

// File: rtl/baud_frac_div_pkg.sv
package baud_frac_div_pkg;
    localparam int unsigned DEF_MANT_W = 8;
    localparam int unsigned DEF_FRAC_W = 4;
    localparam int unsigned DEF_DATA_W = 8;
    localparam logic        ADDR_MANT  = 1'b0;
    localparam logic        ADDR_FRAC  = 1'b1;
endpackage

// File: rtl/frac_div_regs.sv
module frac_div_regs
    import baud_frac_div_pkg::*;
#(
    parameter int unsigned MANT_W = DEF_MANT_W,
    parameter int unsigned FRAC_W = DEF_FRAC_W,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              commit_o,
    output logic [MANT_W-1:0] new_mant_o,
    output logic [FRAC_W-1:0] new_frac_o
);
    typedef struct packed {
        logic [MANT_W-1:0] mant;
        logic [FRAC_W-1:0] frac;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            if (addr == ADDR_FRAC) begin
                st_d.frac = wdata[FRAC_W-1:0];
            end else begin
                st_d.mant = wdata[MANT_W-1:0];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_FRAC) begin
            rdata[FRAC_W-1:0] = st_q.frac;
        end else begin
            rdata[MANT_W-1:0] = st_q.mant;
        end
    end

    // The commit carries the incoming integer and the already staged fraction.
    assign commit_o   = wr_en && (addr == ADDR_MANT);
    assign new_mant_o = wdata[MANT_W-1:0];
    assign new_frac_o = st_q.frac;

    always_comb begin
        if (rst_n && addr == ADDR_FRAC) begin
            AST_RSVD_ZERO: assert (rdata[DATA_W-1:FRAC_W] == '0); // R2
        end
    end

    AST_FRAC_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && addr == ADDR_FRAC) |=> $stable(st_q.frac)); // R2
endmodule

// File: rtl/frac_tick_gen.sv
module frac_tick_gen
    import baud_frac_div_pkg::*;
#(
    parameter int unsigned MANT_W = DEF_MANT_W,
    parameter int unsigned FRAC_W = DEF_FRAC_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              commit_i,
    input  logic [MANT_W-1:0] mant_i,
    input  logic [FRAC_W-1:0] frac_i,
    output logic              tick_o
);
    localparam int unsigned CW = MANT_W + 1;
    localparam int unsigned SW = FRAC_W + 1;

    typedef struct packed {
        logic [MANT_W-1:0] act_mant;
        logic [FRAC_W-1:0] act_frac;
        logic [MANT_W-1:0] cnt;
        logic [FRAC_W-1:0] acc;
        logic              tick;
    } gen_t;

    gen_t st_d, st_q;

    logic [SW-1:0] phase_sum;
    logic          stretch;
    logic [CW-1:0] last_cnt;
    logic          running;
    logic          period_end;

    always_comb begin
        phase_sum  = {1'b0, st_q.acc} + {1'b0, st_q.act_frac};
        stretch    = phase_sum[FRAC_W];
        last_cnt   = {1'b0, st_q.act_mant} - CW'(1) + {{MANT_W{1'b0}}, stretch};
        running    = (st_q.act_mant != '0);
        period_end = running && ({1'b0, st_q.cnt} == last_cnt);

        st_d      = st_q;
        st_d.tick = 1'b0;
        if (commit_i) begin
            st_d.act_mant = mant_i;
            st_d.act_frac = frac_i;
            st_d.cnt      = '0;
            st_d.acc      = '0;
        end else if (period_end) begin
            st_d.tick = 1'b1;
            st_d.cnt  = '0;
            st_d.acc  = phase_sum[FRAC_W-1:0];
        end else if (running) begin
            st_d.cnt  = st_q.cnt + MANT_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign tick_o = st_q.tick;

    AST_ZERO_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.act_mant == '0) |-> !tick_o); // R6
    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (tick_o && st_q.act_mant > MANT_W'(1)) |=> !tick_o); // R7
    AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        running |-> ({1'b0, st_q.cnt} <= {1'b0, st_q.act_mant})); // R8
    AST_STAGED_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        !commit_i |=> $stable(st_q.act_frac) && $stable(st_q.act_mant)); // R4
    AST_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        commit_i |=> (st_q.cnt == '0) && (st_q.acc == '0) && !tick_o); // R5
endmodule

// File: rtl/baud_frac_div.sv
module baud_frac_div
    import baud_frac_div_pkg::*;
#(
    parameter int unsigned MANT_W = DEF_MANT_W,
    parameter int unsigned FRAC_W = DEF_FRAC_W,
    parameter int unsigned DATA_W = DEF_DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic              addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              tick
);
    logic              commit;
    logic [MANT_W-1:0] new_mant;
    logic [FRAC_W-1:0] new_frac;

    frac_div_regs #(
        .MANT_W(MANT_W), .FRAC_W(FRAC_W), .DATA_W(DATA_W)
    ) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .addr       (addr),
        .wdata      (wdata),
        .rdata      (rdata),
        .commit_o   (commit),
        .new_mant_o (new_mant),
        .new_frac_o (new_frac)
    );

    frac_tick_gen #(
        .MANT_W(MANT_W), .FRAC_W(FRAC_W)
    ) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .commit_i (commit),
        .mant_i   (new_mant),
        .frac_i   (new_frac),
        .tick_o   (tick)
    );

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> !tick); // R3
endmodule

// File: tb/baud_frac_div_bench.sv
module baud_frac_div_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       addr = 1'b0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic       tick;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    baud_frac_div u_baud_frac_div (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .tick(tick)
    );

    // Behavioural reference model
    int m_mant = 0, m_frac = 0, a_m = 0, a_f = 0, acc = 0;
    int cyc = 0, nxt = 0, commit_cyc = 0;
    bit exp_tick = 1'b0, prev_tick = 1'b0;
    int tq[$];

    function automatic int plen(int am, int af, int ac);
        return am + (((ac + af) >= 16) ? 1 : 0);
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_mant = 0; m_frac = 0; a_m = 0; a_f = 0; acc = 0;
            nxt = 0; exp_tick = 1'b0;
        end else begin
            cyc++;
            exp_tick = 1'b0;
            if (wr_en && addr) m_frac = int'(wdata[3:0]);
            if (wr_en && !addr) begin
                m_mant = int'(wdata); a_m = m_mant; a_f = m_frac; acc = 0;
                commit_cyc = cyc;
                nxt = cyc + plen(a_m, a_f, acc);
            end else if (a_m != 0 && cyc == nxt) begin
                exp_tick = 1'b1;
                acc = (acc + a_f) % 16;
                nxt = cyc + plen(a_m, a_f, acc);
            end
        end
    end

    task automatic chk(bit ok, string req, int act, int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            chk(tick === exp_tick, "R8 tick timing", int'(tick), int'(exp_tick));
            chk(rdata === (addr ? 8'(m_frac) : 8'(m_mant)), "R9 readback",
                int'(rdata), addr ? m_frac : m_mant);
            if (tick && prev_tick && a_m >= 2)
                chk(1'b0, "R7 tick width", 2, 1);
            if (tick) tq.push_back(cyc);
            prev_tick = tick;
        end
    end

    task automatic wr(logic a, logic [7:0] d);
        @(posedge clk); #1;
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
        tq.delete();
    endtask

    task automatic rd(logic a, int exp, string req);
        @(posedge clk); #1;
        addr = a;
        #2;
        chk(rdata === 8'(exp), req, int'(rdata), exp);
    endtask

    task automatic measure(int m, int f, bit first_check);
        while (tq.size() < 17) @(negedge clk);
        if (first_check)
            chk(tq[0] - commit_cyc == m, "R5 first tick after commit", tq[0] - commit_cyc, m);
        chk(tq[16] - tq[0] == 16 * m + f, "R1 16-interval sum", tq[16] - tq[0], 16 * m + f);
        for (int i = 0; i < 16; i++) begin
            int d = tq[i + 1] - tq[i];
            chk(d == m || d == m + 1, "R8 interval range", d, m);
        end
    endtask

    initial begin
        repeat (5) @(posedge clk);
        #1;
        chk(tick === 1'b0, "R3 tick in reset", int'(tick), 0);
        rst_n = 1'b1;
        rd(1'b0, 0, "R3 integer reset");
        rd(1'b1, 0, "R3 fraction reset");
        repeat (40) @(posedge clk);
        chk(tq.size() == 0, "R3 no tick after reset", tq.size(), 0);

        wr(1'b1, 8'hFC);
        rd(1'b1, 12, "R2 fraction reserved bits");
        wr(1'b0, 8'd27);
        rd(1'b0, 27, "R9 integer readback");
        measure(27, 12, 1'b1);

        wr(1'b1, 8'h03);  // staged only
        rd(1'b1, 3, "R2 staged fraction");
        measure(27, 12, 1'b0); // R4 timing unchanged
        wr(1'b0, 8'd5);
        measure(5, 3, 1'b1);

        wr(1'b1, 8'h0F); wr(1'b0, 8'd3);  measure(3, 15, 1'b1);
        wr(1'b1, 8'h00); wr(1'b0, 8'd2);  measure(2, 0, 1'b1);
        wr(1'b0, 8'd1);                   measure(1, 0, 1'b1);
        wr(1'b1, 8'h0F); wr(1'b0, 8'd1);  measure(1, 15, 1'b1);
        wr(1'b0, 8'd255);                 measure(255, 15, 1'b1);
        wr(1'b1, 8'h07); wr(1'b0, 8'd10); measure(10, 7, 1'b1);

        wr(1'b0, 8'd0);
        repeat (600) @(posedge clk);
        #1;
        chk(tq.size() == 0, "R6 zero integer gates tick", tq.size(), 0);
        rd(1'b0, 0, "R9 zero readback");

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule